// File: doc/BRIEF.md
# Summation-Frame Ring Slave Node

This block is one slave station on a ring bus that moves all process data in one summation frame. The node puts a shift register in series with the ring. Every bit the master sends passes through it, entering at the least significant end and leaving from the most significant end one shift enable at a time. The master ends each pass with a global update strobe. By then the register holds exactly the word meant for this node. On the strobe the node copies that word to its parallel outputs and loads its parallel input word into the register. The next pass then carries the input word on toward the master.

The node works in one of two modes. In data mode the ring path is a data register whose length is a parameter set to the node's number of I/O bits. In identification mode the path is always 16 bits long. An update or a reset loads that path with the node's fixed identity code, so the master can read the device class and register length. The bits the master shifts into the same path are kept at the update as a command word, for example a local reset request. The master picks the mode for the next pass by presenting the mode request at an update. The request is sampled only then, so a pass never changes length part way through.

Top module: `ring_slave_node`

## Requirements
- R1: A synchronous reset (`rst` high) clears `out_word` and `cmd_word`, selects identification mode, loads the identification path with `ID_CODE` and clears the data path. Right after reset, `ser_out` shows bit 15 of `ID_CODE`.
- R2: In data mode, each cycle with `shift_en` high and `update` low moves the data path one place toward its MSB. `ser_in` enters at bit 0, and `ser_out` always shows bit `DATA_W-1`, so a bit comes out `DATA_W` shifts after it went in.
- R3: An update in data mode copies the whole data path to `out_word`. In the same cycle the data path loads `in_word`, which is then shifted out MSB first.
- R4: `out_word` changes only on an update taken in data mode, or on reset. Shifting never disturbs it.
- R5: In identification mode the path is 16 bits long for any `DATA_W`. It holds `ID_CODE` after reset or an update, and shifts it out MSB first while `ser_in` enters at bit 0.
- R6: An update in identification mode copies the 16 bits then in the identification path to `cmd_word`. `cmd_word` changes at no other time except reset.
- R7: `mode_req` (1 = identification, 0 = data) is sampled only on an update and takes effect for the cycles after it. The capture made by that update uses the mode in force before it.
- R8: When `update` and `shift_en` are high in the same cycle, the update is performed and no shift takes place.
- R9: Every update reloads both paths, the data path with `in_word` and the identification path with `ID_CODE`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift the active path by one bit this cycle |
| ser_in | input | 1 | Serial bit from the upstream neighbour |
| ser_out | output | 1 | Serial bit to the downstream neighbour (MSB of the active path) |
| update | input | 1 | Global update strobe ending a pass |
| mode_req | input | 1 | Mode for the next pass, sampled at update (1 = identification) |
| in_word | input | DATA_W | Parallel input data loaded into the frame at update |
| out_word | output | DATA_W | Latched parallel output data |
| cmd_word | output | 16 | Latched command word from the last identification pass |

## Verification
The hardest cases to reach from the ports are the mode switch at an update and an update that falls in the same cycle as a shift. In a mode switch, the capture has to follow the old mode while the serial output at once follows the new path. In a collision, a correct design and one that shifts first differ by only one bit position. Random stimulus presents the mode request on every cycle, and about one cycle in six is an update whose shift enable is random. This produces many switches in both directions and many collisions. Directed passes first read the identity code out bit by bit and shift a command in. They then carry a full data frame through with a data width different from 16.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
   localparam int unsigned IDENT_W = 16;

   typedef enum logic {
      MODE_DATA  = 1'b0,
      MODE_IDENT = 1'b1
   } rsn_mode_e;
endpackage

// File: rtl/rsn_shift_reg.sv
// Serial shift register with a parallel load that takes priority over shifting.
module rsn_shift_reg #(
   parameter int unsigned     W       = 8,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          shift,
   input  logic          load,
   input  logic [W-1:0]  load_val,
   input  logic          sin,
   output logic [W-1:0]  q
);
   generate
      if (W < 2) begin : g_bad_width
         $error("rsn_shift_reg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_VAL;
      end else if (load) begin
         q <= load_val;
      end else if (shift) begin
         q <= {q[W-2:0], sin};
      end
   end
endmodule

// File: rtl/rsn_capture.sv
// Parallel holding register written only on a capture pulse.
module rsn_capture #(
   parameter int unsigned W = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (cap) begin
         q <= d;
      end
   end
endmodule

// File: rtl/rsn_mode_ctl.sv
// Holds the active path selection; changes only at an update.
module rsn_mode_ctl
   import rsn_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       update,
   input  logic       mode_req,
   output rsn_mode_e  mode
);
   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= MODE_IDENT;
      end else if (update) begin
         mode <= mode_req ? MODE_IDENT : MODE_DATA;
      end
   end
endmodule

// File: rtl/ring_slave_node.sv
module ring_slave_node
   import rsn_pkg::*;
#(
   parameter int unsigned          DATA_W  = 16,
   parameter logic [IDENT_W-1:0]   ID_CODE = 16'h0B12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               shift_en,
   input  logic               ser_in,
   output logic               ser_out,
   input  logic               update,
   input  logic               mode_req,
   input  logic [DATA_W-1:0]  in_word,
   output logic [DATA_W-1:0]  out_word,
   output logic [IDENT_W-1:0] cmd_word
);
   localparam int unsigned DMSB = DATA_W - 1;
   localparam int unsigned IMSB = IDENT_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("ring_slave_node: DATA_W must be at least 2");
      end
   endgenerate

   rsn_mode_e          mode;
   logic               in_data, in_ident;
   logic               data_shift, ident_shift;
   logic [DATA_W-1:0]  data_path;
   logic [IDENT_W-1:0] ident_path;

   assign in_data     = (mode == MODE_DATA);
   assign in_ident    = (mode == MODE_IDENT);
   // the update strobe wins over a shift in the same cycle
   assign data_shift  = shift_en & ~update & in_data;
   assign ident_shift = shift_en & ~update & in_ident;

   rsn_mode_ctl u_mode (
      .clk      (clk),
      .rst      (rst),
      .update   (update),
      .mode_req (mode_req),
      .mode     (mode)
   );

   rsn_shift_reg #(.W(DATA_W), .RST_VAL('0)) u_data_path (
      .clk      (clk),
      .rst      (rst),
      .shift    (data_shift),
      .load     (update),
      .load_val (in_word),
      .sin      (ser_in),
      .q        (data_path)
   );

   rsn_shift_reg #(.W(IDENT_W), .RST_VAL(ID_CODE)) u_ident_path (
      .clk      (clk),
      .rst      (rst),
      .shift    (ident_shift),
      .load     (update),
      .load_val (ID_CODE),
      .sin      (ser_in),
      .q        (ident_path)
   );

   rsn_capture #(.W(DATA_W)) u_out_latch (
      .clk (clk),
      .rst (rst),
      .cap (update & in_data),
      .d   (data_path),
      .q   (out_word)
   );

   rsn_capture #(.W(IDENT_W)) u_cmd_latch (
      .clk (clk),
      .rst (rst),
      .cap (update & in_ident),
      .d   (ident_path),
      .q   (cmd_word)
   );

   assign ser_out = in_ident ? ident_path[IMSB] : data_path[DMSB];
endmodule

// File: rtl/rsn_node_checks.sv
module rsn_node_checks #(
   parameter int unsigned   DATA_W  = 16,
   parameter logic [15:0]   ID_CODE = 16'h0B12
) (
   input logic               clk,
   input logic               rst,
   input logic               shift_en,
   input logic               update,
   input logic               ser_out,
   input logic [DATA_W-1:0]  out_word,
   input logic [15:0]        cmd_word
);
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_word == '0 && cmd_word == '0)); // R1

   AST_RESET_SEROUT: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ser_out == ID_CODE[15])); // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(update)) |-> $stable(out_word)); // R4

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(update)) |-> $stable(cmd_word)); // R6

   AST_SEROUT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(update) && !$past(shift_en)) |-> $stable(ser_out)); // R2
endmodule

bind ring_slave_node rsn_node_checks #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .shift_en (shift_en),
   .update   (update),
   .ser_out  (ser_out),
   .out_word (out_word),
   .cmd_word (cmd_word)
);

// File: tb/ring_slave_node_test.sv
module ring_slave_node_test;
   localparam int unsigned W      = 12;
   localparam logic [15:0] IDC    = 16'hB7E1;
   localparam time         T_CLK  = 10ns;

   logic          clk = 1'b0;
   logic          rst, shift_en, ser_in, update, mode_req;
   logic [W-1:0]  in_word;
   logic          ser_out;
   logic [W-1:0]  out_word;
   logic [15:0]   cmd_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state, evolved from the requirements
   logic [W-1:0]  m_data;
   logic [15:0]   m_id;
   logic          m_ident;
   logic [W-1:0]  m_out;
   logic [15:0]   m_cmd;

   ring_slave_node #(.DATA_W(W), .ID_CODE(IDC)) uut (
      .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
      .update(update), .mode_req(mode_req), .in_word(in_word),
      .out_word(out_word), .cmd_word(cmd_word)
   );

   always #(T_CLK/2) clk = ~clk;

   function automatic logic exp_serout();
      return m_ident ? m_id[15] : m_data[W-1];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_data = '0; m_id = IDC; m_ident = 1'b1; m_out = '0; m_cmd = '0;
   endtask

   // one cycle: check the present state at the negedge, drive, advance the model
   task automatic step(input logic r, input logic sh, input logic up, input logic mr,
                       input logic si, input logic [W-1:0] iw, output logic so);
      @(negedge clk);
      so = ser_out;
      check(m_ident ? "R5 ser_out (ident path)" : "R2 ser_out (data path)", 32'(ser_out), 32'(exp_serout()));
      check("R3/R4 out_word", 32'(out_word), 32'(m_out));
      check("R6 cmd_word", 32'(cmd_word), 32'(m_cmd));
      rst = r; shift_en = sh; update = up; mode_req = mr; ser_in = si; in_word = iw;
      if (r) begin
         model_reset();
      end else if (up) begin            // R8: update wins; R7: capture uses old mode; R9
         if (m_ident) m_cmd = m_id; else m_out = m_data;
         m_data  = iw;
         m_id    = IDC;
         m_ident = mr;
      end else if (sh) begin
         if (m_ident) m_id = {m_id[14:0], si};
         else         m_data = {m_data[W-2:0], si};
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic          so;
      logic [15:0]   got16;
      logic [W-1:0]  gotw;
      logic [W-1:0]  frame;
      logic [W-1:0]  inw;
      void'($urandom(32'd4711));
      rst = 1'b1; shift_en = 0; update = 0; mode_req = 0; ser_in = 0; in_word = '0;
      repeat (3) @(negedge clk);
      model_reset();
      // R1 reset state
      @(negedge clk);
      check("R1 out_word after reset", 32'(out_word), 32'h0);
      check("R1 cmd_word after reset", 32'(cmd_word), 32'h0);
      check("R1 ser_out after reset", 32'(ser_out), 32'(IDC[15]));
      // R5: read the identity code while shifting a command in
      got16 = '0;
      for (int k = 0; k < 16; k++) begin
         logic [15:0] cmdv = 16'hA5C3;
         step(1'b0, 1'b1, 1'b0, 1'b0, cmdv[15-k], '0, so);
         got16 = {got16[14:0], so};
      end
      check("R5 identity code read MSB first", 32'(got16), 32'(IDC));
      // R6/R7: update switches to data mode, captures command
      inw = W'(12'h9D4);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, inw, so);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, so);
      check("R6 command captured", 32'(cmd_word), 32'hA5C3);
      // R2/R3: carry a frame through and read the loaded inputs out
      frame = W'(12'h3E7);
      gotw  = '0;
      for (int k = 0; k < W; k++) begin
         step(1'b0, 1'b1, 1'b0, 1'b0, frame[W-1-k], '0, so);
         gotw = {gotw[W-2:0], so};
      end
      check("R3 in_word emerges MSB first", 32'(gotw), 32'(inw));
      check("R4 out_word unchanged by shifting", 32'(out_word), 32'h0);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, W'(12'h111), so);   // R8 collision
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, so);
      check("R3 frame latched to out_word", 32'(out_word), 32'(frame));
      check("R8 ser_out after colliding update", 32'(ser_out), 32'(1'b0));
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic r  = ($urandom_range(0, 299) == 0);
         logic up = ($urandom_range(0, 5) == 0);
         logic sh = ($urandom_range(0, 3) != 0);
         step(r, sh, up, 1'($urandom), 1'($urandom), W'($urandom), so);
      end
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, so);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule